// File: doc/BRIEF.md
# Memory Protection Region Checker

This block decides whether an access may proceed. It covers a 32-bit address space and holds a set of programmable protection regions. Each region sits at a naturally aligned base and spans a power-of-two number of bytes. The region is divided into eight equal slices, and each slice can be switched off on its own. Every region also carries a permission code, an execute-never flag and a set of memory-type bits.

Software programs the block through three 32-bit registers:

- a global control word;
- a base word, which also selects the region being programmed;
- an attribute word, which applies to the region currently selected.

The access side is purely combinational. It takes an address, an access kind (read, write or instruction fetch) and a privilege flag. It returns a fault flag together with the memory-type bits of the region that decided the outcome.

When regions overlap, the highest-numbered region that matches decides. Privileged code is checked only against execute-never. A privileged access that matches no region may use a default map, if the control word allows it.

Top module: `prot_region_unit`

## Requirements
- R1: A write to the base word (regSel=1) whose bit 4 is set selects the region numbered by bits [3:0]. The write stores bits [31:5] as that region's base. If bit 4 is clear, the base goes to the region already selected. Reading the base word returns the stored base in [31:5], 0 in bit 4, and the selected region number in [3:0].
- R2: A write to the attribute word (regSel=2) stores all 32 bits for the selected region, and a read returns them. The fields are: bit 0 enable, [5:1] size code, [15:8] slice-disable, [21:16] TEX/S/C/B, [25:24] permission, 28 execute-never. Writing zero disables the region, so it never matches.
- R3: A size code N covers 2^(N+1) bytes at the aligned base. N=31 covers every address. A region whose code is below 4 never matches.
- R4: Slice-disable bit i removes the i-th eighth of a region, with bit 0 covering the lowest eighth. An address in a removed slice does not match that region. With all eight bits set, the region matches nothing.
- R5: For an unprivileged access that matches a region, the permission code decides:
  - 11 allows every kind of access;
  - 10 faults writes only;
  - 01 or 00 faults every access.
- R6: An instruction fetch (accKind=2) that matches a region with execute-never set faults at both privilege levels.
- R7: A privileged access is never checked against the permission code. The control word's default-map bit (bit 2) governs a privileged access that matches no region: if the bit is set, the access is allowed; if it is clear, the access faults.
- R8: With the block enabled, an unprivileged access that matches no region faults.
- R9: When several regions match, the highest-numbered one decides both the permission and the memory-type bits.
- R10: While control bit 0 (enable) is clear, no access faults and accAttr is 0.
- R11: accAttr presents attribute bits [21:16] ({TEX[2:0],S,C,B}) of the deciding region. It is 0 when no region matches.
- R12: A read of the control word (regSel=0) returns enable in bit 0 and default-map in bit 2, with all other bits 0. A regSel value of 3 is ignored on writes and reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset; clears all registers |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 2 | Write target: 0 control, 1 base, 2 attribute |
| regWrData | input | 32 | Register write data |
| regRdSel | input | 2 | Read source, same encoding as regSel |
| regRdData | output | 32 | Register read data (combinational) |
| accAddr | input | 32 | Access address |
| accKind | input | 2 | 0 read, 1 write, 2 fetch, 3 treated as read |
| accPriv | input | 1 | 1 for privileged access |
| accFault | output | 1 | Access denied |
| accAttr | output | 6 | {TEX,S,C,B} of the deciding region |

## Verification
The bench uses the default of eight regions. This makes index 7 the top of the priority order. The bench places a region covering the whole address space there, so that it overrides every lower region and can then be disabled with a zero attribute write. Eight regions also leave enough room to hold nested regions (0 and 6), an execute-never region, a slice-masked region and an undersized region all at once. Each outcome can then be checked against a different winner.

// File: rtl/prot_pkg.sv
package prot_pkg;
  localparam int ADDR_W = 32;
  localparam int MIN_SIZE_CODE = 4;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_BASE = 2'd1,
    SEL_ATTR = 2'd2,
    SEL_NONE = 2'd3
  } regSel_e;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_OTHER = 2'd3
  } accKind_e;

  typedef struct packed {
    logic ctrlWr;
    logic baseWr;
    logic attrWr;
  } regStrobes_t;
endpackage

// File: rtl/prot_ctrl.sv
module prot_ctrl
  import prot_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  localparam int IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [1:0]       regSel,
  input  logic [4:0]       selField,
  output regStrobes_t      strobes,
  output logic [IDX_W-1:0] tgtIdx,
  output logic [IDX_W-1:0] curSel
);
  logic selValid;
  logic selInRange;
  logic isBase;

  assign isBase     = regWrEn && (regSel == SEL_BASE);
  assign selValid   = selField[4];
  assign selInRange = ({28'd0, selField[3:0]} < 32'(NUM_REGIONS));

  // Base writes naming a region that does not exist are dropped.
  always_comb begin
    strobes.ctrlWr = regWrEn && (regSel == SEL_CTRL);
    strobes.attrWr = regWrEn && (regSel == SEL_ATTR);
    strobes.baseWr = isBase && !(selValid && !selInRange);
    tgtIdx = (isBase && selValid && selInRange) ? selField[IDX_W-1:0] : curSel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      curSel <= '0;
    else if (isBase && selValid && selInRange)
      curSel <= selField[IDX_W-1:0];
  end

  AST_SEL_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    (isBase && selValid && selInRange) |=> (curSel == $past(selField[IDX_W-1:0]))); // R1
  AST_SEL_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    !(isBase && selValid) |=> $stable(curSel)); // R1
endmodule

// File: rtl/prot_path.sv
module prot_path
  import prot_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  localparam int IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  regStrobes_t      strobes,
  input  logic [IDX_W-1:0] tgtIdx,
  input  logic [IDX_W-1:0] curSel,
  input  logic [31:0]      regWrData,
  input  logic [1:0]       regRdSel,
  output logic [31:0]      regRdData,
  input  logic [31:0]      accAddr,
  input  logic [1:0]       accKind,
  input  logic             accPriv,
  output logic             accFault,
  output logic [5:0]       accAttr
);
  logic             ctrlEn;
  logic             defMapEn;
  logic [26:0]      baseRegs [NUM_REGIONS];
  logic [31:0]      attrRegs [NUM_REGIONS];
  logic [NUM_REGIONS-1:0] hitVec;
  logic [IDX_W-1:0] winner;
  logic             anyHit;
  logic [31:0]      winAttr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlEn   <= 1'b0;
      defMapEn <= 1'b0;
      for (int i = 0; i < NUM_REGIONS; i++) begin
        baseRegs[i] <= '0;
        attrRegs[i] <= '0;
      end
    end else begin
      if (strobes.ctrlWr) begin
        ctrlEn   <= regWrData[0];
        defMapEn <= regWrData[2];
      end
      if (strobes.baseWr) baseRegs[tgtIdx] <= regWrData[31:5];
      if (strobes.attrWr) attrRegs[tgtIdx] <= regWrData;
    end
  end

  always_comb begin
    case (regRdSel)
      SEL_CTRL: regRdData = {29'd0, defMapEn, 1'b0, ctrlEn};
      SEL_BASE: regRdData = {baseRegs[curSel], 1'b0, 4'(curSel)};
      SEL_ATTR: regRdData = attrRegs[curSel];
      default:  regRdData = 32'd0;
    endcase
  end

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : gRegion
    logic [4:0]  sizeN;
    logic [32:0] span;
    logic [31:0] lowMask;
    logic [2:0]  subIdx;
    logic        inRange;
    logic [7:0]  srd;

    always_comb begin
      sizeN   = attrRegs[g][5:1];
      srd     = attrRegs[g][15:8];
      span    = 33'd1 << ({1'b0, sizeN} + 6'd1);
      lowMask = span[31:0] - 32'd1;
      inRange = (((accAddr ^ {baseRegs[g], 5'd0}) & ~lowMask) == 32'd0);
      subIdx  = 3'(accAddr >> (sizeN - 5'd2));
      hitVec[g] = attrRegs[g][0] && (sizeN >= 5'(MIN_SIZE_CODE)) &&
                  inRange && !srd[subIdx];
    end
  end

  // Ascending scan: the last (highest-numbered) hit overrides earlier ones.
  always_comb begin
    winner = '0;
    for (int i = 0; i < NUM_REGIONS; i++)
      if (hitVec[i]) winner = IDX_W'(i);
    anyHit  = |hitVec;
    winAttr = attrRegs[winner];
  end

  always_comb begin
    accFault = 1'b0;
    accAttr  = 6'd0;
    if (ctrlEn) begin
      if (anyHit) begin
        accAttr = winAttr[21:16];
        if (accKind == ACC_FETCH && winAttr[28])
          accFault = 1'b1;
        else if (!accPriv) begin
          case (winAttr[25:24])
            2'b11:   accFault = 1'b0;
            2'b10:   accFault = (accKind == ACC_WRITE);
            default: accFault = 1'b1;
          endcase
        end
      end else begin
        accFault = !(accPriv && defMapEn);
      end
    end
  end

  AST_ATTR_STORED: assert property (@(posedge clk) disable iff (!rstN)
    strobes.attrWr |=> (attrRegs[curSel] == $past(regWrData))); // R2
  AST_OFF_ALLOWS: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlEn |-> (!accFault && accAttr == 6'd0)); // R10
  AST_PRIV_DATA_OK: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlEn && defMapEn && accPriv && accKind != ACC_FETCH) |-> !accFault); // R7
  AST_UNPRIV_MISS: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlEn && !anyHit && !accPriv) |-> accFault); // R8
  AST_MISS_NO_ATTR: assert property (@(posedge clk) disable iff (!rstN)
    !anyHit |-> (accAttr == 6'd0)); // R11
  AST_CTRL_STORED: assert property (@(posedge clk) disable iff (!rstN)
    strobes.ctrlWr |=> (ctrlEn == $past(regWrData[0]))); // R12
endmodule

// File: rtl/prot_region_unit.sv
module prot_region_unit
  import prot_pkg::*;
#(
  parameter int NUM_REGIONS = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [1:0]  regSel,
  input  logic [31:0] regWrData,
  input  logic [1:0]  regRdSel,
  output logic [31:0] regRdData,
  input  logic [31:0] accAddr,
  input  logic [1:0]  accKind,
  input  logic        accPriv,
  output logic        accFault,
  output logic [5:0]  accAttr
);
  localparam int IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;

  regStrobes_t      strobes;
  logic [IDX_W-1:0] tgtIdx;
  logic [IDX_W-1:0] curSel;

  prot_ctrl #(.NUM_REGIONS(NUM_REGIONS)) uCtrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .selField(regWrData[4:0]), .strobes(strobes), .tgtIdx(tgtIdx), .curSel(curSel)
  );

  prot_path #(.NUM_REGIONS(NUM_REGIONS)) uPath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .tgtIdx(tgtIdx), .curSel(curSel),
    .regWrData(regWrData), .regRdSel(regRdSel), .regRdData(regRdData),
    .accAddr(accAddr), .accKind(accKind), .accPriv(accPriv),
    .accFault(accFault), .accAttr(accAttr)
  );
endmodule

// File: tb/tb_prot_region_unit.sv
module tb_prot_region_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regSel = 2'd0;
  logic [31:0] regWrData = 32'd0;
  logic [1:0]  regRdSel = 2'd0;
  logic [31:0] regRdData;
  logic [31:0] accAddr = 32'd0;
  logic [1:0]  accKind = 2'd0;
  logic        accPriv = 1'b0;
  logic        accFault;
  logic [5:0]  accAttr;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  prot_region_unit #(.NUM_REGIONS(8)) dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel), .regWrData(regWrData),
    .regRdSel(regRdSel), .regRdData(regRdData), .accAddr(accAddr), .accKind(accKind),
    .accPriv(accPriv), .accFault(accFault), .accAttr(accAttr)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [31:0] data);
    @(negedge clk);
    regWrEn = 1'b1; regSel = sel; regWrData = data;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(logic [1:0] sel, logic [31:0] exp, string req);
    @(negedge clk);
    regRdSel = sel;
    #2;
    chk(req, regRdData, exp);
  endtask

  task automatic acc(logic [31:0] addr, logic [1:0] kind, logic priv,
                     logic expFault, logic [5:0] expAttr, string req);
    @(negedge clk);
    accAddr = addr; accKind = kind; accPriv = priv;
    #2;
    chk(req, {31'd0, accFault}, {31'd0, expFault});
    chk(req, {26'd0, accAttr}, {26'd0, expAttr});
  endtask

  task automatic setRegion(int idx, logic [31:0] base, logic [31:0] attr);
    wr(2'd1, base | 32'h10 | 32'(idx));
    wr(2'd2, attr);
  endtask

  task automatic t_reset();
    rd(2'd0, 32'd0, "R12 reset ctrl");
    acc(32'h1234, 2'd1, 1'b0, 1'b0, 6'd0, "R10 disabled after reset");
  endtask

  task automatic t_regs();
    wr(2'd1, 32'h2000_0013);
    rd(2'd1, 32'h2000_0003, "R1 base readback");
    wr(2'd2, 32'h0300_0A13);
    rd(2'd2, 32'h0300_0A13, "R2 attr readback");
    wr(2'd1, 32'h4000_0000);
    rd(2'd1, 32'h4000_0003, "R1 base write keeps selection");
    wr(2'd2, 32'd0);
    rd(2'd2, 32'd0, "R2 attr cleared");
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, 32'h5, "R12 ctrl keeps bits 0 and 2");
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd3, 32'd0, "R12 unused select reads zero");
    rd(2'd1, 32'h4000_0003, "R12 unused select write ignored");
  endtask

  task automatic t_perm();
    setRegion(0, 32'h1000, 32'h0300_0013);
    setRegion(1, 32'h2000, 32'h0200_0013);
    setRegion(2, 32'h3000, 32'h0100_0013);
    acc(32'h1000, 2'd0, 1'b0, 1'b0, 6'd0, "R3 region start");
    acc(32'h13FF, 2'd1, 1'b0, 1'b0, 6'd0, "R3 region last byte");
    acc(32'h1400, 2'd0, 1'b0, 1'b1, 6'd0, "R8 past region end");
    acc(32'h0FFF, 2'd0, 1'b0, 1'b1, 6'd0, "R8 below region");
    acc(32'h2000, 2'd0, 1'b0, 1'b0, 6'd0, "R5 read-only read");
    acc(32'h2004, 2'd1, 1'b0, 1'b1, 6'd0, "R5 read-only write");
    acc(32'h2008, 2'd2, 1'b0, 1'b0, 6'd0, "R5 read-only fetch");
    acc(32'h3000, 2'd0, 1'b0, 1'b1, 6'd0, "R5 no-access read");
    acc(32'h3000, 2'd1, 1'b0, 1'b1, 6'd0, "R5 no-access write");
    acc(32'h3000, 2'd0, 1'b1, 1'b0, 6'd0, "R7 privileged ignores permission");
    acc(32'h3004, 2'd1, 1'b1, 1'b0, 6'd0, "R7 privileged write ignores permission");
    setRegion(5, 32'h5000, 32'h0300_0007);
    acc(32'h5000, 2'd0, 1'b0, 1'b1, 6'd0, "R3 undersized region never matches");
  endtask

  task automatic t_subregion();
    setRegion(3, 32'h8000, 32'h0300_0415);
    acc(32'h8000, 2'd0, 1'b0, 1'b0, 6'd0, "R4 slice 0 on");
    acc(32'h8200, 2'd0, 1'b0, 1'b1, 6'd0, "R4 slice 2 off");
    acc(32'h8300, 2'd0, 1'b0, 1'b0, 6'd0, "R4 slice 3 on");
    acc(32'h87FF, 2'd1, 1'b0, 1'b0, 6'd0, "R4 slice 7 on");
    acc(32'h8800, 2'd0, 1'b0, 1'b1, 6'd0, "R3 beyond 2KiB region");
    setRegion(3, 32'h8000, 32'h0300_FF15);
    acc(32'h8000, 2'd0, 1'b0, 1'b1, 6'd0, "R4 all slices off");
    acc(32'h87FF, 2'd0, 1'b0, 1'b1, 6'd0, "R4 all slices off top");
  endtask

  task automatic t_xn();
    setRegion(1, 32'h2000, 32'h1300_0013);
    acc(32'h2000, 2'd2, 1'b0, 1'b1, 6'd0, "R6 unprivileged fetch");
    acc(32'h2000, 2'd2, 1'b1, 1'b1, 6'd0, "R6 privileged fetch");
    acc(32'h2000, 2'd0, 1'b0, 1'b0, 6'd0, "R6 read unaffected");
    acc(32'h1000, 2'd2, 1'b1, 1'b0, 6'd0, "R6 fetch elsewhere allowed");
  endtask

  task automatic t_priority();
    setRegion(6, 32'h1000, 32'h020B_000F);
    acc(32'h1000, 2'd1, 1'b0, 1'b1, 6'h0B, "R9 higher region denies write");
    acc(32'h10FF, 2'd0, 1'b0, 1'b0, 6'h0B, "R11 attr of winner");
    acc(32'h1100, 2'd1, 1'b0, 1'b0, 6'h00, "R9 lower region outside overlap");
    setRegion(7, 32'h0, 32'h0307_003F);
    acc(32'h3000, 2'd1, 1'b0, 1'b0, 6'h07, "R9 full-space region wins");
    acc(32'hFFFF_FFF0, 2'd1, 1'b0, 1'b0, 6'h07, "R3 size 31 covers top");
    wr(2'd2, 32'd0);
    acc(32'hFFFF_FFF0, 2'd0, 1'b0, 1'b1, 6'h00, "R2 zero attr disables");
  endtask

  task automatic t_defmap();
    acc(32'h9000_0000, 2'd0, 1'b1, 1'b0, 6'd0, "R7 default map on");
    wr(2'd0, 32'h1);
    acc(32'h9000_0000, 2'd0, 1'b1, 1'b1, 6'd0, "R7 default map off");
    acc(32'h9000_0000, 2'd2, 1'b1, 1'b1, 6'd0, "R7 default map off fetch");
    acc(32'h9000_0000, 2'd0, 1'b0, 1'b1, 6'd0, "R8 unprivileged miss");
  endtask

  task automatic t_disable();
    wr(2'd0, 32'h0);
    acc(32'h3000, 2'd1, 1'b0, 1'b0, 6'd0, "R10 no-access region allowed when off");
    acc(32'h2000, 2'd2, 1'b0, 1'b0, 6'd0, "R10 execute-never ignored when off");
    acc(32'h1000, 2'd0, 1'b0, 1'b0, 6'd0, "R10 attr zero when off");
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_regs();
    t_perm();
    t_subregion();
    t_xn();
    t_priority();
    t_defmap();
    t_disable();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule